// File: doc/BRIEF.md
# DDR Read-Path Per-Bit Deskew Calibrator

This block runs read-side deskew training for a 32-bit DDR data path organised as four byte lanes. On one start pulse it takes over an external read/compare test engine. It fires the engine with a single-cycle pulse and waits for its completion level. It then waits a fixed settling interval before it captures the engine's 32-bit compare-error word, in which a set bit means that data bit failed. From these results it chooses a 4-bit input delay for every data bit and a 7-bit input delay for every lane strobe.

Training has two sweeps. In the first, every data-bit delay is stepped together from tap 0. Each bit keeps the last tap that still passed before its first failure. In the second, the four strobe delays are stepped together over their full range. One tracker per bit records the widest run of passing taps. At the end, each lane's strobe delay is set to the largest window centre among its eight bits. Each bit's data delay is then raised by the gap between that lane value and its own centre, capped at the top tap. A done pulse reports the result, with a pass flag that is set only when every bit produced a window.

Top module: `ddr_rx_deskew_cal`

## Requirements
- R1: After reset, every delay field, `cal_done`, `cal_pass` and `te_start` are zero, and the block waits idle.
- R2: A `cal_start` pulse while idle sets every data and strobe delay to zero before the first test run. A `cal_start` pulse during calibration has no effect: the run count and the results are unchanged.
- R3: Each test run is a one-cycle `te_start` pulse followed by waiting for `te_done` high. No delay output changes between that pulse and the rise of `te_done`.
- R4: The error word is captured exactly `SETTLE_CYC` cycles after the first cycle in which `te_done` is seen high, never earlier.
- R5: In the first sweep all data delays carry the same tap t, starting at 0. For bit i, with error bit i = 1 meaning fail, the block records the last passing tap before that bit's first failure. Once a bit has failed, its record never changes. A bit that fails at tap 0 records 0.
- R6: The first sweep stops after the run at tap 15, or earlier after a run whose error word is all ones. The recorded taps are then applied as the data delays.
- R7: The second sweep sets all four strobe fields to the same tap, from 0 to 127, with one test run per tap. A full calibration therefore issues (first-sweep runs + 128) test runs.
- R8: For each bit, the chosen window is the longest contiguous run of passing strobe taps. On a tie the earlier run wins. A run that still passes at tap 127 ends at 127.
- R9: A bit's centre is floor((lowest + highest tap of its window) / 2). A bit with no window has centre 0.
- R10: The final strobe delay of lane k is the largest centre among bits 8k to 8k+7.
- R11: The final data delay of bit i is min(15, recorded tap + lane strobe delay - centre of bit i).
- R12: `dq_dly` holds bit i's delay in bits [8i+7:8i], and `dqs_dly` holds lane k's delay in bits [8k+7:8k]. Unused upper bits of each field read zero.
- R13: Completion is a one-cycle `cal_done` pulse, with the final delays already on the outputs. `cal_pass` is 1 only if every bit had a window, and it holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Start pulse for a calibration |
| cal_done | output | 1 | One-cycle completion pulse |
| cal_pass | output | 1 | Every bit found a passing window |
| te_start | output | 1 | Test-engine launch pulse |
| te_done | input | 1 | Test-engine completion level |
| te_err | input | 32 | Per-bit compare error word, 1 = fail |
| dq_dly | output | 256 | Per-bit data input delays, 8-bit fields |
| dqs_dly | output | 32 | Per-lane strobe input delays, 8-bit fields |

## Verification
The bench's test-engine model drives an all-ones error word until the settling interval has fully elapsed. A capture taken even one cycle early therefore ends the first sweep at tap 0 and corrupts every data delay. Directed bit windows cover the other corner cases:
- Two equal-length passing runs: a design that keeps the later run reports a different centre.
- A window that is still open at tap 127, including a single-tap window there: a design that never closes it loses the window and clears the pass flag.
- A lane whose centres lie more than 100 taps apart: a design without saturation wraps the 4-bit delay.

Other scenarios force an early all-fail exit from the first sweep, which shows up as a shorter run count, and a stray start pulse in mid-calibration, which a restarting design would reveal by its run count.

// File: rtl/ddrcal_pkg.sv
package ddrcal_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GO,
      ST_WAIT,
      ST_SETTLE,
      ST_EVAL,
      ST_FINAL
   } cal_state_t;

endpackage

// File: rtl/ddrcal_window.sv
module ddrcal_window #(
   parameter int TAP_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             smp,
   input  logic             fail,
   input  logic             last,
   input  logic [TAP_W-1:0] tap,
   output logic [TAP_W-1:0] center,
   output logic             found
);

   logic             in_win;
   logic [TAP_W-1:0] cur_lo;
   logic [TAP_W-1:0] best_lo, best_hi;
   logic             pass_c, close_c, wider_c;
   logic [TAP_W-1:0] lo_c, hi_c;
   logic [TAP_W:0]   mid_sum;

   always_comb begin
      pass_c  = smp & ~fail;
      lo_c    = in_win ? cur_lo : tap;
      hi_c    = fail ? (tap - 1'b1) : tap;
      close_c = smp & ((in_win & fail) | (pass_c & last));
      wider_c = ~found | ((hi_c - lo_c) > (best_hi - best_lo));
      mid_sum = {1'b0, best_lo} + {1'b0, best_hi};
      center  = found ? mid_sum[TAP_W:1] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_win  <= 1'b0;
         cur_lo  <= '0;
         best_lo <= '0;
         best_hi <= '0;
         found   <= 1'b0;
      end else if (clr) begin
         in_win  <= 1'b0;
         cur_lo  <= '0;
         best_lo <= '0;
         best_hi <= '0;
         found   <= 1'b0;
      end else if (smp) begin
         if (pass_c && !in_win) cur_lo <= tap;
         in_win <= pass_c & ~last;
         if (close_c && wider_c) begin
            best_lo <= lo_c;
            best_hi <= hi_c;
            found   <= 1'b1;
         end
      end
   end

   AST_WIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (best_lo <= best_hi)); // R8
   AST_WIN_SHUT_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (smp && fail) |=> !in_win); // R8
   AST_CENTER_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (center >= best_lo && center <= best_hi)); // R9

endmodule

// File: rtl/ddrcal_lane_fix.sv
module ddrcal_lane_fix #(
   parameter int LANE_BITS = 8,
   parameter int DQ_TAP_W  = 4,
   parameter int DQS_TAP_W = 7
) (
   input  logic [LANE_BITS*DQS_TAP_W-1:0] centers,
   input  logic [LANE_BITS*DQ_TAP_W-1:0]  rec_taps,
   output logic [DQS_TAP_W-1:0]           lane_dqs,
   output logic [LANE_BITS*DQ_TAP_W-1:0]  dq_fix
);

   localparam int SUM_W = DQS_TAP_W + 1;
   localparam logic [SUM_W-1:0] SAT_LIM = SUM_W'((1 << DQ_TAP_W) - 1);

   function automatic logic [DQ_TAP_W-1:0] push_late(
      input logic [DQ_TAP_W-1:0]  rec,
      input logic [DQS_TAP_W-1:0] lane_v,
      input logic [DQS_TAP_W-1:0] cen
   );
      logic [SUM_W-1:0] s;
      s = SUM_W'(rec) + SUM_W'(lane_v - cen);
      return (s > SAT_LIM) ? SAT_LIM[DQ_TAP_W-1:0] : s[DQ_TAP_W-1:0];
   endfunction

   always_comb begin
      lane_dqs = '0;
      for (int b = 0; b < LANE_BITS; b++) begin
         if (centers[b*DQS_TAP_W +: DQS_TAP_W] > lane_dqs)
            lane_dqs = centers[b*DQS_TAP_W +: DQS_TAP_W];
      end
   end

   always_comb begin
      for (int b = 0; b < LANE_BITS; b++) begin
         dq_fix[b*DQ_TAP_W +: DQ_TAP_W] = push_late(rec_taps[b*DQ_TAP_W +: DQ_TAP_W],
                                                    lane_dqs,
                                                    centers[b*DQS_TAP_W +: DQS_TAP_W]);
      end
   end

   always_comb begin
      for (int b = 0; b < LANE_BITS; b++) begin
         if (!$isunknown({dq_fix, rec_taps}))
            AST_NEVER_EARLIER: assert (dq_fix[b*DQ_TAP_W +: DQ_TAP_W] >=
                                       rec_taps[b*DQ_TAP_W +: DQ_TAP_W]); // R11
      end
   end

endmodule

// File: rtl/ddr_rx_deskew_cal.sv
module ddr_rx_deskew_cal
   import ddrcal_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int LANE_BITS  = 8,
   parameter int DQ_TAP_W   = 4,
   parameter int DQS_TAP_W  = 7,
   parameter int FIELD_W    = 8,
   parameter int SETTLE_CYC = 50
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cal_start,
   output logic                           cal_done,
   output logic                           cal_pass,
   output logic                           te_start,
   input  logic                           te_done,
   input  logic [LANES*LANE_BITS-1:0]     te_err,
   output logic [LANES*LANE_BITS*FIELD_W-1:0] dq_dly,
   output logic [LANES*FIELD_W-1:0]       dqs_dly
);

   localparam int NBITS   = LANES * LANE_BITS;
   localparam int CNT_W   = $clog2(SETTLE_CYC + 1);
   localparam logic [DQ_TAP_W-1:0]  DQ_MAX  = '1;
   localparam logic [DQS_TAP_W-1:0] DQS_MAX = '1;
   localparam logic [CNT_W-1:0]     SET_END = CNT_W'(SETTLE_CYC - 1);

   if (FIELD_W <= DQS_TAP_W) begin : g_bad_field
      $error("FIELD_W must exceed DQS_TAP_W");
   end
   if (DQS_TAP_W < DQ_TAP_W) begin : g_bad_taps
      $error("DQS_TAP_W must be at least DQ_TAP_W");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end

   cal_state_t           state;
   logic                 ph2;
   logic [DQ_TAP_W-1:0]  dq_cnt;
   logic [DQS_TAP_W-1:0] dqs_cnt;
   logic [CNT_W-1:0]     settle_cnt;
   logic [NBITS-1:0]     err_q;
   logic [NBITS-1:0]     rec_done;
   logic [DQ_TAP_W-1:0]  rec_tap [NBITS];
   logic [DQ_TAP_W-1:0]  rec_nxt [NBITS];
   logic [DQ_TAP_W-1:0]  dq_q    [NBITS];
   logic [DQS_TAP_W-1:0] dqs_q   [LANES];
   logic                 done_q, pass_q;

   logic [DQS_TAP_W-1:0] cen_w   [NBITS];
   logic [NBITS-1:0]     found_w;
   logic [DQS_TAP_W-1:0] lane_dqs [LANES];
   logic [DQ_TAP_W-1:0]  dq_fix  [NBITS];
   logic                 trk_clr, trk_smp, trk_last;

   assign te_start = (state == ST_GO);
   assign cal_done = done_q;
   assign cal_pass = pass_q;
   assign trk_clr  = (state == ST_IDLE) && cal_start;
   assign trk_smp  = (state == ST_EVAL) && ph2;
   assign trk_last = (dqs_cnt == DQS_MAX);

   always_comb begin
      for (int i = 0; i < NBITS; i++)
         rec_nxt[i] = (!err_q[i] && !rec_done[i]) ? dq_cnt : rec_tap[i];
   end

   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      ddrcal_window #(.TAP_W(DQS_TAP_W)) u_win (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (trk_clr),
         .smp    (trk_smp),
         .fail   (err_q[i]),
         .last   (trk_last),
         .tap    (dqs_cnt),
         .center (cen_w[i]),
         .found  (found_w[i])
      );
      assign dq_dly[i*FIELD_W +: FIELD_W] = {{(FIELD_W-DQ_TAP_W){1'b0}}, dq_q[i]};
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [LANE_BITS*DQS_TAP_W-1:0] cen_flat;
      logic [LANE_BITS*DQ_TAP_W-1:0]  rec_flat;
      logic [LANE_BITS*DQ_TAP_W-1:0]  fix_flat;
      for (genvar b = 0; b < LANE_BITS; b++) begin : g_pack
         assign cen_flat[b*DQS_TAP_W +: DQS_TAP_W] = cen_w[k*LANE_BITS+b];
         assign rec_flat[b*DQ_TAP_W +: DQ_TAP_W]   = rec_tap[k*LANE_BITS+b];
         assign dq_fix[k*LANE_BITS+b] = fix_flat[b*DQ_TAP_W +: DQ_TAP_W];
      end
      ddrcal_lane_fix #(
         .LANE_BITS (LANE_BITS),
         .DQ_TAP_W  (DQ_TAP_W),
         .DQS_TAP_W (DQS_TAP_W)
      ) u_fix (
         .centers  (cen_flat),
         .rec_taps (rec_flat),
         .lane_dqs (lane_dqs[k]),
         .dq_fix   (fix_flat)
      );
      assign dqs_dly[k*FIELD_W +: FIELD_W] = {{(FIELD_W-DQS_TAP_W){1'b0}}, dqs_q[k]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         ph2        <= 1'b0;
         dq_cnt     <= '0;
         dqs_cnt    <= '0;
         settle_cnt <= '0;
         err_q      <= '0;
         rec_done   <= '0;
         done_q     <= 1'b0;
         pass_q     <= 1'b0;
         for (int i = 0; i < NBITS; i++) begin
            rec_tap[i] <= '0;
            dq_q[i]    <= '0;
         end
         for (int k = 0; k < LANES; k++) dqs_q[k] <= '0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: if (cal_start) begin
               ph2      <= 1'b0;
               dq_cnt   <= '0;
               dqs_cnt  <= '0;
               rec_done <= '0;
               pass_q   <= 1'b0;
               for (int i = 0; i < NBITS; i++) begin
                  rec_tap[i] <= '0;
                  dq_q[i]    <= '0;
               end
               for (int k = 0; k < LANES; k++) dqs_q[k] <= '0;
               state <= ST_GO;
            end
            ST_GO: begin
               settle_cnt <= '0;
               state      <= ST_WAIT;
            end
            ST_WAIT: if (te_done) state <= ST_SETTLE;
            ST_SETTLE: begin
               if (settle_cnt == SET_END) begin
                  err_q <= te_err;
                  state <= ST_EVAL;
               end else begin
                  settle_cnt <= settle_cnt + 1'b1;
               end
            end
            ST_EVAL: begin
               state <= ST_GO;
               if (!ph2) begin
                  rec_done <= rec_done | err_q;
                  for (int i = 0; i < NBITS; i++) rec_tap[i] <= rec_nxt[i];
                  if ((&err_q) || (dq_cnt == DQ_MAX)) begin
                     ph2 <= 1'b1;
                     for (int i = 0; i < NBITS; i++) dq_q[i] <= rec_nxt[i];
                  end else begin
                     dq_cnt <= dq_cnt + 1'b1;
                     for (int i = 0; i < NBITS; i++) dq_q[i] <= dq_cnt + 1'b1;
                  end
               end else if (dqs_cnt == DQS_MAX) begin
                  state <= ST_FINAL;
               end else begin
                  dqs_cnt <= dqs_cnt + 1'b1;
                  for (int k = 0; k < LANES; k++) dqs_q[k] <= dqs_cnt + 1'b1;
               end
            end
            ST_FINAL: begin
               for (int k = 0; k < LANES; k++) dqs_q[k] <= lane_dqs[k];
               for (int i = 0; i < NBITS; i++) dq_q[i] <= dq_fix[i];
               done_q <= 1'b1;
               pass_q <= &found_w;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      te_start |=> !te_start); // R3
   AST_HOLD_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT || state == ST_SETTLE) |=> ($stable(dq_dly) && $stable(dqs_dly))); // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |=> !cal_done); // R13
   AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SETTLE) |-> (settle_cnt <= SET_END)); // R4

   for (genvar i = 0; i < NBITS; i++) begin : g_sticky
      AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (rec_done[i] && state != ST_IDLE) |=> rec_done[i]); // R5
   end

endmodule

// File: tb/sim_ddr_rx_deskew_cal.sv
module sim_ddr_rx_deskew_cal;

   localparam int SETTLE = 12;
   localparam int NB     = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cal_start = 1'b0;
   logic         cal_done, cal_pass, te_start;
   logic         te_done;
   logic [31:0]  te_err;
   logic [255:0] dq_dly;
   logic [31:0]  dqs_dly;

   always #4 clk = ~clk;

   ddr_rx_deskew_cal #(.SETTLE_CYC(SETTLE)) u0 (
      .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_done(cal_done),
      .cal_pass(cal_pass), .te_start(te_start), .te_done(te_done), .te_err(te_err),
      .dq_dly(dq_dly), .dqs_dly(dqs_dly)
   );

   int n_chk = 0;
   int n_fail = 0;

   int lim [NB];
   int wa1 [NB];
   int wb1 [NB];
   int wa2 [NB];
   int wb2 [NB];

   function automatic bit dqs_ok(int i, int t);
      return (t >= wa1[i] && t <= wb1[i]) || (t >= wa2[i] && t <= wb2[i]);
   endfunction

   // test engine model
   int lat;
   int since;
   logic [31:0] model_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         te_done <= 1'b0;
         lat     <= 0;
         since   <= 0;
      end else begin
         if (te_start) begin
            te_done <= 1'b0;
            lat     <= $urandom_range(1, 5);
         end else if (lat > 0) begin
            lat <= lat - 1;
            if (lat == 1) te_done <= 1'b1;
         end
         if (!te_done) since <= 0;
         else if (since < 1000) since <= since + 1;
      end
   end

   always_comb begin
      for (int i = 0; i < NB; i++) begin
         model_err[i] = !((lim[i] >= 0) &&
                          (int'(dq_dly[i*8 +: 8]) <= lim[i]) &&
                          dqs_ok(i, int'(dqs_dly[(i/8)*8 +: 8])));
      end
   end
   assign te_err = (te_done && since >= SETTLE) ? model_err : 32'hFFFF_FFFF;

   // monitors
   int runs = 0;
   int base_runs = 0;
   bit first_zero = 1'b0;
   int proto_bad = 0;
   bit prev_go = 1'b0;
   bit in_test = 1'b0;
   logic [255:0] prev_dq;
   logic [31:0]  prev_dqs;

   always @(posedge clk) begin
      if (te_start && runs == base_runs)
         first_zero <= (dq_dly == '0) && (dqs_dly == '0);
      if (te_start) runs <= runs + 1;
      if (te_start && prev_go) proto_bad <= proto_bad + 1;
      if (in_test && (dq_dly !== prev_dq || dqs_dly !== prev_dqs)) proto_bad <= proto_bad + 1;
      prev_go  <= te_start;
      prev_dq  <= dq_dly;
      prev_dqs <= dqs_dly;
      if (te_start) in_test <= 1'b1;
      else if (te_done) in_test <= 1'b0;
   end

   task automatic chk(bit ok, string tag, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // expected values
   int e_rec [NB];
   int e_cen [NB];
   int e_dqs [4];
   int e_dq  [NB];
   bit e_pass;
   int e_runs;

   task automatic compute_expected();
      int t_all;
      t_all = 0;
      e_pass = 1'b1;
      for (int i = 0; i < NB; i++) begin
         int fs;
         if (lim[i] < 0 || !dqs_ok(i, 0)) begin
            e_rec[i] = 0; fs = 0;
         end else begin
            e_rec[i] = (lim[i] > 15) ? 15 : lim[i]; fs = lim[i] + 1;
         end
         if (fs > t_all) t_all = fs;
      end
      e_runs = ((t_all <= 15) ? t_all + 1 : 16) + 128;
      for (int i = 0; i < NB; i++) begin
         int lo, hi, blo, bhi;
         bit open, fnd;
         open = 0; fnd = 0; lo = 0; blo = 0; bhi = 0;
         for (int t = 0; t < 128; t++) begin
            bit p;
            p = (lim[i] >= 0) && dqs_ok(i, t);
            if (p && !open) begin open = 1; lo = t; end
            if (open && (!p || t == 127)) begin
               hi = p ? t : t - 1;
               if (!fnd || (hi - lo) > (bhi - blo)) begin blo = lo; bhi = hi; fnd = 1; end
               open = 0;
            end
         end
         e_cen[i] = fnd ? (blo + bhi) / 2 : 0;
         if (!fnd) e_pass = 1'b0;
      end
      for (int k = 0; k < 4; k++) begin
         e_dqs[k] = 0;
         for (int b = 0; b < 8; b++) if (e_cen[k*8+b] > e_dqs[k]) e_dqs[k] = e_cen[k*8+b];
      end
      for (int i = 0; i < NB; i++) begin
         int v;
         v = e_rec[i] + e_dqs[i/8] - e_cen[i];
         e_dq[i] = (v > 15) ? 15 : v;
      end
   endtask

   task automatic random_cfg();
      for (int i = 0; i < NB; i++) begin
         lim[i] = $urandom_range(0, 18);
         wa1[i] = ($urandom_range(0, 3) != 0) ? 0 : $urandom_range(1, 40);
         wb1[i] = wa1[i] + $urandom_range(0, 30);
         if ($urandom_range(0, 3) == 0) begin
            wa2[i] = 1; wb2[i] = 0;
         end else begin
            wa2[i] = wb1[i] + 2 + $urandom_range(0, 20);
            wb2[i] = wa2[i] + $urandom_range(0, 50);
            if (wb2[i] > 127) wb2[i] = 127;
         end
      end
   endtask

   task automatic run_cal(string name, bit poke_mid);
      int guard;
      compute_expected();
      @(negedge clk);
      base_runs = runs;
      cal_start = 1'b1;
      @(negedge clk);
      cal_start = 1'b0;
      guard = 0;
      while (!cal_done && guard < 40000) begin
         @(negedge clk);
         guard++;
         if (poke_mid && guard == 300) cal_start = 1'b1;
         else cal_start = 1'b0;
      end
      cal_start = 1'b0;
      chk(guard < 40000, {name, " R13 cal_done seen"}, guard, 0);
      if (guard >= 40000) return;
      chk(first_zero, {name, " R2 delays zero at first run"}, first_zero, 1);
      chk(runs - base_runs == e_runs, {name, " R6 R7 R4 run count"}, runs - base_runs, e_runs);
      chk(cal_pass == e_pass, {name, " R13 R9 pass flag"}, cal_pass, e_pass);
      for (int k = 0; k < 4; k++)
         chk(int'(dqs_dly[k*8 +: 8]) == e_dqs[k], {name, " R10 R8 R12 lane strobe delay"},
             dqs_dly[k*8 +: 8], e_dqs[k]);
      for (int i = 0; i < NB; i++)
         chk(int'(dq_dly[i*8 +: 8]) == e_dq[i], {name, " R11 R5 R12 bit data delay"},
             dq_dly[i*8 +: 8], e_dq[i]);
      @(negedge clk);
      chk(!cal_done, {name, " R13 done is one cycle"}, cal_done, 0);
      chk(cal_pass == e_pass, {name, " R13 pass held"}, cal_pass, e_pass);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd91));
      for (int i = 0; i < NB; i++) begin
         lim[i] = 15; wa1[i] = 0; wb1[i] = 127; wa2[i] = 1; wb2[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dq_dly == '0 && dqs_dly == '0, "R1 delays zero after reset", dqs_dly, 0);
      chk(!cal_done && !cal_pass && !te_start, "R1 control outputs low after reset",
          {cal_done, cal_pass, te_start}, 0);

      // A: directed windows
      random_cfg();
      lim[0] = 9;  wa1[0] = 0;  wb1[0] = 3;  wa2[0] = 120; wb2[0] = 127;
      lim[1] = 6;  wa1[1] = 10; wb1[1] = 19; wa2[1] = 40;  wb2[1] = 49;
      lim[2] = 3;  wa1[2] = 0;  wb1[2] = 8;  wa2[2] = 30;  wb2[2] = 60;
      lim[3] = 15; wa1[3] = 127; wb1[3] = 127; wa2[3] = 1; wb2[3] = 0;
      lim[4] = 20; wa1[4] = 0;  wb1[4] = 127; wa2[4] = 1;  wb2[4] = 0;
      lim[5] = 2;  wa1[5] = 0;  wb1[5] = 3;  wa2[5] = 1;   wb2[5] = 0;
      lim[6] = 7;  wa1[6] = 50; wb1[6] = 90; wa2[6] = 1;   wb2[6] = 0;
      lim[8] = 4;  wa1[8] = 100; wb1[8] = 127; wa2[8] = 1; wb2[8] = 0;
      lim[9] = 11; wa1[9] = 0;  wb1[9] = 4;  wa2[9] = 1;   wb2[9] = 0;
      run_cal("directed", 1'b0);

      // B: early all-fail exit of the first sweep
      random_cfg();
      for (int i = 0; i < NB; i++) begin
         lim[i] = $urandom_range(0, 4); wa1[i] = 0;
      end
      run_cal("early_exit", 1'b0);

      // C: random
      random_cfg();
      run_cal("random", 1'b0);

      // D: random with a stray start in mid-run
      random_cfg();
      run_cal("start_ignored R2", 1'b1);

      // E: bits without any window
      random_cfg();
      wa1[17] = 5; wb1[17] = 4; wa2[17] = 1; wb2[17] = 0;
      lim[20] = -1;
      run_cal("no_window", 1'b0);

      chk(proto_bad == 0, "R3 launch pulse and delay hold", proto_bad, 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule